// File: doc/BRIEF.md
# Adaptive Luma Notch Coring Selector

This block decides, one luma sample at a time, whether the sample should pass through a small notch filter. The notch filter removes leftover colour subcarrier that shows up as crawling dots in flat parts of the picture. Each accepted sample is compared with the sample accepted just before it. When the absolute step between them is small, the area counts as flat, and the block emits the notch-filtered value. When the step is large, the area counts as detail, and the block emits the unfiltered sample, delayed so that it lines up with the filter.

Two fixed notch kernels are built in, and a select input chooses one of them for each sample. A 2-bit code chooses how small the step must be for the area to count as flat. An enable input turns notch substitution off, so that every sample takes the delayed unfiltered path.

A small fill state machine tracks the sample history. It has two states. `ST_EMPTY` is entered at reset, and in this state the history holds no sample, so the previous-sample value used for the comparison is forced to zero. The first sample accepted with valid high moves the machine to `ST_PRIMED`. It stays in `ST_PRIMED` until the next reset.

Top module: `luma_notch_selector`

## Requirements
- R1: While reset is held and right after it is released, `dout_valid` is 0 and `dout` is 0. Every history tap is cleared to zero.
- R2: A sample accepted with `din_valid` high appears as one output with `dout_valid` high exactly 3 clocks later. No output appears for any other cycle. `dout` holds its last value while `dout_valid` is low.
- R3: The step for sample x[n] is |x[n] − x[n−1]|. The first sample after reset is compared with 0 (state `ST_EMPTY`). Every later sample is compared with the previously accepted sample (state `ST_PRIMED`).
- R4: `thr_sel` sets the flat test as a strict less-than. Code 2'b00 means step < 16, 2'b01 means step < 12, 2'b10 means step < 8, and 2'b11 means step < 4.
- R5: When the step passes the flat test and `core_en` is 1, the output is the filtered value. Otherwise the output is the bypass value of the selected kernel.
- R6: When `fsel`=0, the filtered value is (x[n] + 2·x[n−1] + x[n−2]) >> 2, truncated, and the bypass value is x[n−1].
- R7: When `fsel`=1, the filtered value is (x[n] + 2·x[n−2] + x[n−4]) >> 2, truncated, and the bypass value is x[n−2].
- R8: A cycle with `din_valid` low leaves the history unchanged, whatever `din` holds.
- R9: `thr_sel`, `core_en` and `fsel` are captured together with each sample, so they can change on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | W | Pedestal-stripped luma sample |
| din_valid | input | 1 | Marks `din` as a sample to process |
| thr_sel | input | 2 | Flat-step threshold code |
| core_en | input | 1 | Allows substitution of the filtered value |
| fsel | input | 1 | Kernel select: 0 three-tap, 1 five-tap spaced |
| dout | output | W | Selected luma |
| dout_valid | output | 1 | Marks `dout` as a new output sample |

## Verification
The first sample after reset is chosen so that a comparison with zero and a comparison with any stale value give different outputs. For each threshold code, the bench sends pairs of samples whose step sits one below the limit and exactly at the limit, which separates the four limits and exposes off-by-one compares. Pseudo-random streams run with each kernel, with the enable both on and off, so that a wrong tap, a wrong weight or a wrong bypass alignment changes the values. Streams with gaps and garbage on `din`, and streams whose controls change on every sample, show whether history shifting and control capture follow the valid sample rather than the clock.

// File: rtl/lns_pkg.sv
package lns_pkg;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_PRIMED = 1'b1
    } fill_state_t;

    // Flat-step limit for each threshold code (strict less-than compare)
    function automatic logic [4:0] step_limit(input logic [1:0] code);
        logic [4:0] lim;
        unique case (code)
            2'b00:   lim = 5'd16;
            2'b01:   lim = 5'd12;
            2'b10:   lim = 5'd8;
            default: lim = 5'd4;
        endcase
        return lim;
    endfunction

    // Kernel weight of history tap k (tap 0 = newest) for kernel f
    function automatic logic [1:0] kernel_weight(input int f, input int k);
        logic [1:0] w;
        if (f == 0) w = (k == 1) ? 2'd2 : ((k == 0 || k == 2) ? 2'd1 : 2'd0);
        else        w = (k == 2) ? 2'd2 : ((k == 0 || k == 4) ? 2'd1 : 2'd0);
        return w;
    endfunction

    // Tap that the bypass path takes so it lines up with kernel f
    function automatic int kernel_center(input int f);
        return (f == 0) ? 1 : 2;
    endfunction

endpackage

// File: rtl/lns_history.sv
module lns_history
    import lns_pkg::*;
#(
    parameter int W     = 10,
    parameter int DEPTH = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            din,
    input  logic                    din_valid,
    output logic [DEPTH-1:0][W-1:0] taps,
    output logic [W-1:0]            prev
);

    fill_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        prev    = taps[0];
        unique case (state_q)
            ST_EMPTY: begin
                prev = '0;
                if (din_valid) state_d = ST_PRIMED;
            end
            ST_PRIMED: begin
                prev = taps[0];
            end
        endcase
    end

    // Shift chain, advanced only by accepted samples
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            always_ff @(posedge clk) begin
                if (!rst_n)         taps[i] <= '0;
                else if (din_valid) taps[i] <= (i == 0) ? din : taps[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !din_valid |=> $stable(taps)); // R8
    AST_STAY_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PRIMED |=> state_q == ST_PRIMED); // R3
    AST_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && din_valid) |=> (state_q == ST_PRIMED && taps[0] == $past(din))); // R3

endmodule

// File: rtl/lns_step_detect.sv
module lns_step_detect
    import lns_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [1:0]   code,
    output logic         flat
);

    logic [W-1:0] step;
    logic [W-1:0] limit;

    always_comb begin
        step  = (cur >= prev) ? (cur - prev) : (prev - cur);
        limit = {{(W-5){1'b0}}, step_limit(code)};
        flat  = (step < limit);
    end

endmodule

// File: rtl/lns_notch_bank.sv
module lns_notch_bank
    import lns_pkg::*;
#(
    parameter int W     = 10,
    parameter int DEPTH = 5,
    parameter int NK    = 2
) (
    input  logic [DEPTH-1:0][W-1:0] taps,
    input  logic                    ksel,
    output logic [W-1:0]            filt,
    output logic [W-1:0]            byp
);

    localparam int AW = W + 2;

    logic [NK-1:0][W-1:0] filt_k;
    logic [NK-1:0][W-1:0] byp_k;

    generate
        for (genvar f = 0; f < NK; f++) begin : g_kernel
            logic [AW-1:0] acc;
            always_comb begin
                acc = '0;
                for (int k = 0; k < DEPTH; k++) begin
                    acc = acc + ({2'b00, taps[k]} * AW'(kernel_weight(f, k)));
                end
                filt_k[f] = acc[AW-1:2];
                byp_k[f]  = taps[kernel_center(f)];
            end
        end
    endgenerate

    always_comb begin
        filt = filt_k[ksel];
        byp  = byp_k[ksel];
    end

endmodule

// File: rtl/luma_notch_selector.sv
module luma_notch_selector
    import lns_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         din_valid,
    input  logic [1:0]   thr_sel,
    input  logic         core_en,
    input  logic         fsel,
    output logic [W-1:0] dout,
    output logic         dout_valid
);

    localparam int DEPTH = 5;
    localparam int NK    = 2;

    logic [DEPTH-1:0][W-1:0] taps;
    logic [W-1:0]            prev;
    logic                    flat_c;
    logic [W-1:0]            filt_c, byp_c;

    // Stage 1: step decision and captured controls
    logic v1, flat1, en1, ksel1;
    // Stage 2: filtered and bypass candidates
    logic v2, use2;
    logic [W-1:0] filt2, byp2;

    lns_history #(.W(W), .DEPTH(DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .taps(taps), .prev(prev)
    );

    lns_step_detect #(.W(W)) u_step (
        .cur(din), .prev(prev), .code(thr_sel), .flat(flat_c)
    );

    lns_notch_bank #(.W(W), .DEPTH(DEPTH), .NK(NK)) u_bank (
        .taps(taps), .ksel(ksel1), .filt(filt_c), .byp(byp_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; flat1 <= 1'b0; en1 <= 1'b0; ksel1 <= 1'b0;
            v2 <= 1'b0; use2 <= 1'b0; filt2 <= '0; byp2 <= '0;
            dout <= '0; dout_valid <= 1'b0;
        end else begin
            v1 <= din_valid;
            if (din_valid) begin
                flat1 <= flat_c;
                en1   <= core_en;
                ksel1 <= fsel;
            end
            v2 <= v1;
            if (v1) begin
                use2  <= flat1 & en1;
                filt2 <= filt_c;
                byp2  <= byp_c;
            end
            dout_valid <= v2;
            if (v2) dout <= use2 ? filt2 : byp2;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid |-> ##3 dout_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !din_valid |-> ##3 !dout_valid); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> $stable(dout)); // R2
    AST_DETAIL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && !use2) |=> dout == $past(byp2)); // R5

endmodule

// File: tb/tb_luma_notch_selector.sv
module tb_luma_notch_selector;

    localparam int W = 10;

    typedef struct {
        int    val;
        int    due;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         din_valid = 1'b0;
    logic [1:0]   thr_sel = 2'b00;
    logic         core_en = 1'b0;
    logic         fsel = 1'b0;
    logic [W-1:0] dout;
    logic         dout_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int samp[$];
    exp_t expq[$];
    int seed = 12345;

    luma_notch_selector #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .thr_sel(thr_sel), .core_en(core_en), .fsel(fsel),
        .dout(dout), .dout_valid(dout_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tap(int n, int k);
        return (n - k >= 0) ? samp[n-k] : 0;
    endfunction

    // Expected output for sample n from the requirements R3..R7
    function automatic int model(int n, int code, int en, int fs);
        int step, lim, f, b;
        step = samp[n] - tap(n, 1);
        if (step < 0) step = -step;
        lim = (code == 0) ? 16 : (code == 1) ? 12 : (code == 2) ? 8 : 4;
        if (fs == 0) begin
            f = (tap(n,0) + 2*tap(n,1) + tap(n,2)) / 4;
            b = tap(n,1);
        end else begin
            f = (tap(n,0) + 2*tap(n,2) + tap(n,4)) / 4;
            b = tap(n,2);
        end
        return (step < lim && en != 0) ? f : b;
    endfunction

    function automatic int rnd();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >> 8) & 32'h3ff;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: data checked with the scenario tag, timing against R2
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected output", int'(dout), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cyc == e.due, "R2 latency", cyc, e.due);
                check(int'(dout) == e.val, e.tag, int'(dout), e.val);
            end
        end
    end

    task automatic send(int v, int code, int en, int fs, string tag);
        exp_t e;
        din = W'(v); din_valid = 1'b1;
        thr_sel = 2'(code); core_en = en[0]; fsel = fs[0];
        samp.push_back(v);
        e.val = model(samp.size() - 1, code, en, fs);
        e.due = cyc + 3;
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            din = W'(rnd()); din_valid = 1'b0;
            thr_sel = 2'(rnd()); core_en = 1'b1; fsel = 1'(rnd());
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dout_valid == 1'b0, "R1 valid in reset", int'(dout_valid), 0);
        check(dout == '0, "R1 data in reset", int'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_valid == 1'b0, "R1 valid after reset", int'(dout_valid), 0);
    endtask

    task automatic t_first_pixel();
        // 10 vs zero: step 10 < 16 -> filtered (10)>>2 = 2, bypass would be 0
        send(10, 0, 1, 0, "R3 first sample vs zero");
        send(14, 3, 1, 0, "R3 second sample vs first");
        idle(4);
    endtask

    task automatic t_thresholds();
        int lims[4] = '{16, 12, 8, 4};
        for (int c = 0; c < 4; c++) begin
            send(300, c, 1, 0, "R4 base");
            send(300 + lims[c] - 1, c, 1, 0, "R4 below limit");
            send(300 + 2*lims[c] - 1, c, 1, 0, "R4 at limit");
            send(700, c, 1, 0, "R4 large step");
        end
        idle(4);
    endtask

    task automatic t_kernel_a();
        for (int i = 0; i < 20; i++) send(400 + (rnd() & 15) - 8, 0, 1, 0, "R6 kernel A flat");
        for (int i = 0; i < 12; i++) send(rnd(), 0, 1, 0, "R6 kernel A detail");
        idle(4);
    endtask

    task automatic t_kernel_b();
        for (int i = 0; i < 20; i++) send(600 + (rnd() & 7), 1, 1, 1, "R7 kernel B flat");
        for (int i = 0; i < 12; i++) send(rnd(), 1, 1, 1, "R7 kernel B detail");
        idle(4);
    endtask

    task automatic t_enable_off();
        for (int i = 0; i < 16; i++) send(200 + (rnd() & 3), 0, 0, i % 2, "R5 enable off bypass");
        idle(4);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 24; i++) begin
            send(500 + (rnd() & 15), 0, 1, i % 2, "R8 gaps ignored");
            idle(1 + (i % 3));
        end
        idle(4);
    endtask

    task automatic t_control_switch();
        for (int i = 0; i < 32; i++)
            send(250 + (rnd() & 31), rnd() & 3, (i % 5) != 0, (i / 2) % 2, "R9 per-sample controls");
        idle(4);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
        @(negedge clk);
        t_reset();
        t_first_pixel();
        t_thresholds();
        t_kernel_a();
        t_kernel_b();
        t_enable_off();
        t_gaps();
        t_control_switch();
        idle(6);
        check(expq.size() == 0, "R2 outputs missing", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule